// File: doc/BRIEF.md
# Full-Bridge Motor PWM Generator

This block produces pulse-width modulation for a full H-bridge. A 10-bit timebase counts either upward and wraps (edge-aligned) or upward then downward (center-aligned). Each of two channels compares the count against its own duty value. The result drives a high-side output and a complementary low-side output. A programmable dead band keeps both switches of a leg off for a set number of clocks at every change of state.

Software programs period, duties, dead band and mode through a simple write port. Period and duty writes land in shadow registers, which take effect only when the count returns to zero. This keeps a PWM cycle from being torn mid-way. Each time the count passes through zero, the block emits a one-cycle pulse that a converter can use to start sampling in step with the switching.

Comparator trip lines and external trip pins can each be enabled as fault sources. An enabled fault pulls all four outputs low at once, through a path that does not wait for a clock edge. The fault also latches a stop flag. The stop flag holds the outputs low until software clears it.

Top module: `bridge_pwm`

## Requirements
- R1: While reset is asserted, all four bridge outputs, the converter trigger and the stop flag are low.
- R2: In edge-aligned mode (control bit 0 = 0), the count runs 0 to P-1 and then wraps. With a dead band of 0, a channel's high-side output is high for D of every P clocks, where D is the duty and P the period.
- R3: In center-aligned mode (control bit 0 = 1), the count runs 0 up to P and back down to 1, giving a cycle of 2P clocks. The high-side output is high for 2D-1 of those clocks.
- R4: The low-side output of a channel is never high in the same clock as its high-side output. With a dead band of 0, the low-side output is the exact inverse of the high-side output.
- R5: With a dead band of N clocks, both outputs of a leg stay low for exactly N clocks at every change of state. Each output's rising edge is delayed by N; falling edges are not delayed.
- R6: A duty of 0 holds the high-side output low for the whole cycle. A duty equal to or above the period holds it high for the whole cycle, with no low clock.
- R7: Period and duty writes take effect only at the next return of the count to zero. The cycle in progress keeps its old values. Dead band and control writes take effect at once.
- R8: When an enabled fault input is high, all four outputs go low in the same cycle, without waiting for a clock edge. The stop flag is set at the next clock edge. Control bit 1 enables the comparator fault inputs; control bit 2 enables the pin fault inputs.
- R9: Once set, the stop flag holds all outputs low until a write of 1 in data bit 0 to the clear address. A clear write while an enabled fault is still high leaves the flag set.
- R10: A fault input whose enable bit is 0 does not set the stop flag and does not change the outputs.
- R11: The converter trigger is a single-clock pulse, issued once per cycle in the clock where the count is zero. It repeats every P clocks in edge mode and every 2P clocks in center mode.
- R12: Write addresses are: 0 period; 1 duty of channel 0; 2 duty of channel 1; 3 dead band (low 6 data bits); 4 control; 5 clear stop flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 10 | Register write data |
| cmp_fault | input | 2 | Comparator trip lines, active high |
| pin_fault | input | 2 | External trip pins, active high |
| pwm_hi | output | 2 | High-side output per channel |
| pwm_lo | output | 2 | Complementary low-side output per channel |
| adc_start | output | 1 | One-cycle converter trigger at count zero |
| stop_flag | output | 1 | Latched forced-stop indicator |

## Verification
The duty comparison is tried with a mid-range duty on each channel, in both edge and center counting. The high-time counts differ between the two modes (D versus 2D-1), which tells the modes apart. The same pattern is repeated with a nonzero dead band, which separates a correct rising-edge delay from one that also shortens or delays the falling edge. Duties of zero, exactly the period and above the period exercise the clamp paths. A duty change and a period change written mid-cycle show whether the shadow load waits for the zero point. Fault stimulus is applied with each source enabled and disabled, and a clear is written while the trip is still high.

// File: rtl/bridge_pwm_pkg.sv
package bridge_pwm_pkg;

    // Register addresses; duty slots follow the period slot, one per channel
    localparam int ADR_PERIOD    = 0;
    localparam int ADR_DUTY_BASE = 1;

    function automatic int adr_dead(input int nch);
        return ADR_DUTY_BASE + nch;
    endfunction

    function automatic int adr_ctrl(input int nch);
        return ADR_DUTY_BASE + nch + 1;
    endfunction

    function automatic int adr_clear(input int nch);
        return ADR_DUTY_BASE + nch + 2;
    endfunction

    // Control word bit positions
    localparam int CTL_CENTER = 0;
    localparam int CTL_CMP_EN = 1;
    localparam int CTL_PIN_EN = 2;

endpackage

// File: rtl/bpwm_timebase.sv
module bpwm_timebase #(
    parameter int CNT_W = 10,
    parameter int NCH   = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           center,
    input  logic [CNT_W-1:0]               per_sh,
    input  logic [NCH-1:0][CNT_W-1:0]      duty_sh,
    output logic [NCH-1:0]                 raw,
    output logic                           zero_pulse
);

    typedef struct packed {
        logic [CNT_W-1:0]          cnt;
        logic                      down;
        logic [CNT_W-1:0]          per;
        logic [NCH-1:0][CNT_W-1:0] duty;
        logic                      trig;
    } tb_state_t;

    tb_state_t s_d, s_q;
    logic      load;

    always_comb begin
        s_d  = s_q;
        load = 1'b0;
        if (s_q.per == '0) begin
            s_d.cnt  = '0;
            s_d.down = 1'b0;
            load     = 1'b1;
        end else if (!center) begin
            s_d.down = 1'b0;
            if (s_q.cnt >= s_q.per - 1'b1) begin
                s_d.cnt = '0;
                load    = 1'b1;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end else if (!s_q.down) begin
            if (s_q.cnt >= s_q.per) begin
                if (s_q.per == CNT_W'(1)) begin
                    s_d.cnt = '0;
                    load    = 1'b1;
                end else begin
                    s_d.down = 1'b1;
                    s_d.cnt  = s_q.per - 1'b1;
                end
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end else begin
            if (s_q.cnt <= CNT_W'(1)) begin
                s_d.cnt  = '0;
                s_d.down = 1'b0;
                load     = 1'b1;
            end else begin
                s_d.cnt = s_q.cnt - 1'b1;
            end
        end
        if (load) begin
            s_d.per  = per_sh;
            s_d.duty = duty_sh;
        end
        s_d.trig = load;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    for (genvar ch = 0; ch < NCH; ch++) begin : g_cmp
        assign raw[ch] = (s_q.duty[ch] != '0) &&
                         ((s_q.duty[ch] >= s_q.per) || (s_q.cnt < s_q.duty[ch]));
    end

    assign zero_pulse = s_q.trig;

    // R2 R3
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= s_q.per);

    // R11
    trig_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.trig |-> (s_q.cnt == '0));

    // R7
    shadow_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(s_q.per) |-> s_q.trig);

endmodule

// File: rtl/bpwm_deadband.sv
module bpwm_deadband #(
    parameter int DT_W = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            raw,
    input  logic [DT_W-1:0] dead,
    output logic            hi,
    output logic            lo
);

    typedef struct packed {
        logic            level;
        logic [DT_W-1:0] cnt;
        logic            hi;
        logic            lo;
    } db_state_t;

    db_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (raw != s_q.level) begin
            s_d.level = raw;
            s_d.cnt   = dead;
            if (dead == '0) begin
                s_d.hi = raw;
                s_d.lo = ~raw;
            end else begin
                s_d.hi = 1'b0;
                s_d.lo = 1'b0;
            end
        end else if (s_q.cnt != '0) begin
            s_d.cnt = s_q.cnt - 1'b1;
            if (s_q.cnt == DT_W'(1)) begin
                s_d.hi = s_q.level;
                s_d.lo = ~s_q.level;
            end else begin
                s_d.hi = 1'b0;
                s_d.lo = 1'b0;
            end
        end else begin
            s_d.hi = s_q.level;
            s_d.lo = ~s_q.level;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign hi = s_q.hi;
    assign lo = s_q.lo;

    // R4
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(s_q.hi && s_q.lo));

    // R5
    gap_before_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(s_q.hi) && ($past(dead) != '0)) |-> !$past(s_q.lo));

endmodule

// File: rtl/bpwm_trip.sv
module bpwm_trip #(
    parameter int NFLT = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NFLT-1:0] cmp_fault,
    input  logic [NFLT-1:0] pin_fault,
    input  logic            cmp_en,
    input  logic            pin_en,
    input  logic            clear,
    output logic            fault_now,
    output logic            stop
);

    typedef struct packed {
        logic stop;
    } trip_state_t;

    trip_state_t s_d, s_q;

    always_comb begin
        fault_now = (|(cmp_fault & {NFLT{cmp_en}})) | (|(pin_fault & {NFLT{pin_en}}));
        s_d.stop  = (s_q.stop & ~clear) | fault_now;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign stop = s_q.stop;

    // R8
    stop_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_now |=> s_q.stop);

    // R9
    stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.stop && !clear) |=> s_q.stop);

endmodule

// File: rtl/bridge_pwm.sv
module bridge_pwm #(
    parameter int CNT_W  = 10,
    parameter int NCH    = 2,
    parameter int DT_W   = 6,
    parameter int NFLT   = 2,
    parameter int ADDR_W = $clog2(NCH + 4)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic [NFLT-1:0]   cmp_fault,
    input  logic [NFLT-1:0]   pin_fault,
    output logic [NCH-1:0]    pwm_hi,
    output logic [NCH-1:0]    pwm_lo,
    output logic              adc_start,
    output logic              stop_flag
);
    import bridge_pwm_pkg::*;

    localparam int A_DEAD  = adr_dead(NCH);
    localparam int A_CTRL  = adr_ctrl(NCH);
    localparam int A_CLEAR = adr_clear(NCH);

    typedef struct packed {
        logic [CNT_W-1:0]          per;
        logic [NCH-1:0][CNT_W-1:0] duty;
        logic [DT_W-1:0]           dead;
        logic                      center;
        logic                      cmp_en;
        logic                      pin_en;
    } cfg_t;

    cfg_t   c_d, c_q;
    logic   clear;
    logic   fault_now;
    logic   stop;
    logic   zero_pulse;
    logic   kill;
    logic [NCH-1:0] raw, db_hi, db_lo;

    always_comb begin
        c_d   = c_q;
        clear = 1'b0;
        if (wr_en) begin
            if (wr_addr == ADDR_W'(ADR_PERIOD)) c_d.per = wr_data;
            for (int ch = 0; ch < NCH; ch++) begin
                if (wr_addr == ADDR_W'(ADR_DUTY_BASE + ch)) c_d.duty[ch] = wr_data;
            end
            if (wr_addr == ADDR_W'(A_DEAD)) c_d.dead = wr_data[DT_W-1:0];
            if (wr_addr == ADDR_W'(A_CTRL)) begin
                c_d.center = wr_data[CTL_CENTER];
                c_d.cmp_en = wr_data[CTL_CMP_EN];
                c_d.pin_en = wr_data[CTL_PIN_EN];
            end
            if (wr_addr == ADDR_W'(A_CLEAR)) clear = wr_data[0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    bpwm_timebase #(.CNT_W(CNT_W), .NCH(NCH)) i_timebase (
        .clk        (clk),
        .rst_n      (rst_n),
        .center     (c_q.center),
        .per_sh     (c_q.per),
        .duty_sh    (c_q.duty),
        .raw        (raw),
        .zero_pulse (zero_pulse)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_leg
        bpwm_deadband #(.DT_W(DT_W)) i_deadband (
            .clk   (clk),
            .rst_n (rst_n),
            .raw   (raw[ch]),
            .dead  (c_q.dead),
            .hi    (db_hi[ch]),
            .lo    (db_lo[ch])
        );
    end

    bpwm_trip #(.NFLT(NFLT)) i_trip (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmp_fault (cmp_fault),
        .pin_fault (pin_fault),
        .cmp_en    (c_q.cmp_en),
        .pin_en    (c_q.pin_en),
        .clear     (clear),
        .fault_now (fault_now),
        .stop      (stop)
    );

    assign kill      = stop | fault_now;
    assign pwm_hi    = db_hi & {NCH{~kill}};
    assign pwm_lo    = db_lo & {NCH{~kill}};
    assign adc_start = zero_pulse;
    assign stop_flag = stop;

    // R8
    safe_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_flag |-> ((pwm_hi == '0) && (pwm_lo == '0)));

    // R4
    leg_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_hi & pwm_lo) == '0);

endmodule

// File: tb/test_bridge_pwm.sv
`timescale 1ns/1ps
module test_bridge_pwm;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [9:0] wr_data = '0;
    logic [1:0] cmp_fault = '0;
    logic [1:0] pin_fault = '0;
    logic [1:0] pwm_hi, pwm_lo;
    logic       adc_start, stop_flag;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    int last_trig = -1;
    bit done = 0;

    typedef struct {
        int    gap;
        string req;
    } trig_item_t;
    trig_item_t exp_q[$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc++;

    bridge_pwm i_bridge_pwm (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .cmp_fault(cmp_fault), .pin_fault(pin_fault), .pwm_hi(pwm_hi), .pwm_lo(pwm_lo),
        .adc_start(adc_start), .stop_flag(stop_flag)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0d exp=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic wr(input int adr, input int data);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'(adr); wr_data = 10'(data);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic measure(input int n, input int ch, output int hi_n, output int lo_n,
                           output int both_low, output int same, output int trig_n);
        hi_n = 0; lo_n = 0; both_low = 0; same = 0; trig_n = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pwm_hi[ch]) hi_n++;
            if (pwm_lo[ch]) lo_n++;
            if (!pwm_hi[ch] && !pwm_lo[ch]) both_low++;
            if (pwm_hi[ch] == pwm_lo[ch]) same++;
            if (adc_start) trig_n++;
        end
    endtask

    // Scoreboard driver side: queue expected trigger spacings, wait for them to drain
    task automatic expect_trig(input int gap, input string req, input int n);
        for (int i = 0; i < n; i++) exp_q.push_back('{gap: gap, req: req});
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    // Scoreboard monitor side
    always @(negedge clk) begin
        if (rst_n && adc_start) begin
            if (exp_q.size() != 0 && last_trig >= 0) begin
                trig_item_t it;
                it = exp_q.pop_front();
                check(cyc - last_trig == it.gap, it.req, cyc - last_trig, it.gap);
            end
            last_trig = cyc;
        end
    end

    initial begin
        int h, l, b, s, t;

        idle(5);
        // R1 reset state
        check(pwm_hi == 2'b00 && pwm_lo == 2'b00, "R1 outputs", int'({pwm_hi, pwm_lo}), 0);
        check(adc_start == 1'b0 && stop_flag == 1'b0, "R1 trig/stop",
              int'({adc_start, stop_flag}), 0);
        rst_n = 1'b1;

        // R12 register map: period 0, duty0 1, duty1 2, dead 3, ctrl 4
        wr(0, 20); wr(1, 8); wr(2, 15); wr(3, 0); wr(4, 0);
        idle(60);
        measure(20, 0, h, l, b, s, t);
        check(h == 8, "R2 edge ch0 high", h, 8);
        check(l == 12, "R4 edge ch0 low", l, 12);
        check(s == 0, "R4 complement ch0", s, 0);
        check(t == 1, "R11 one pulse per cycle", t, 1);
        measure(20, 1, h, l, b, s, t);
        check(h == 15 && l == 5, "R2 edge ch1 high", h, 15);
        expect_trig(20, "R11 edge spacing", 3);

        // R5 dead band 3
        wr(3, 3);
        idle(60);
        measure(20, 0, h, l, b, s, t);
        check(h == 5, "R5 high shortened", h, 5);
        check(l == 9, "R5 low shortened", l, 9);
        check(b == 6, "R5 both-low clocks", b, 6);
        check(h + l + b == 20, "R4 no overlap", h + l + b, 20);

        // R3 center mode
        wr(3, 0); wr(4, 1);
        idle(100);
        measure(40, 0, h, l, b, s, t);
        check(h == 15, "R3 center ch0 high", h, 15);
        check(l == 25, "R3 center ch0 low", l, 25);
        expect_trig(40, "R3 center spacing", 2);

        // R6 duty clamps
        wr(4, 0); wr(1, 0); wr(2, 20);
        idle(60);
        measure(20, 0, h, l, b, s, t);
        check(h == 0 && l == 20, "R6 duty zero", h, 0);
        measure(20, 1, h, l, b, s, t);
        check(h == 20 && l == 0, "R6 duty equal period", h, 20);
        wr(2, 700);
        idle(60);
        measure(20, 1, h, l, b, s, t);
        check(h == 20, "R6 duty above period", h, 20);

        // R7 shadow loading
        wr(0, 100); wr(1, 50);
        idle(250);
        @(negedge clk); while (!adc_start) @(negedge clk);
        idle(10);
        wr(1, 5);
        idle(15);
        check(pwm_hi[0] == 1'b1, "R7 duty held mid-cycle", int'(pwm_hi[0]), 1);
        @(negedge clk); while (!adc_start) @(negedge clk);
        idle(15);
        check(pwm_hi[0] == 1'b0, "R7 duty applied next cycle", int'(pwm_hi[0]), 0);
        wr(0, 40);
        expect_trig(100, "R7 period held", 1);
        expect_trig(40, "R7 period applied", 2);

        // R8 / R9 fault with comparator enabled
        wr(0, 20); wr(1, 8); wr(2, 15); wr(4, 2);
        idle(60);
        @(negedge clk);
        cmp_fault = 2'b10;
        #1;
        check(pwm_hi == 2'b00 && pwm_lo == 2'b00, "R8 immediate kill",
              int'({pwm_hi, pwm_lo}), 0);
        @(negedge clk);
        check(stop_flag == 1'b1, "R8 flag set", int'(stop_flag), 1);
        cmp_fault = 2'b00;
        measure(40, 0, h, l, b, s, t);
        check(h + l == 0, "R9 latched ch0", h + l, 0);
        measure(20, 1, h, l, b, s, t);
        check(h + l == 0, "R9 latched ch1", h + l, 0);
        cmp_fault = 2'b01;
        wr(5, 1);
        cmp_fault = 2'b00;
        @(negedge clk);
        check(stop_flag == 1'b1, "R9 clear ignored under fault", int'(stop_flag), 1);
        wr(5, 1);
        check(stop_flag == 1'b0, "R9 clear", int'(stop_flag), 0);
        idle(40);
        measure(20, 0, h, l, b, s, t);
        check(h == 8 && l == 12, "R9 resumed", h, 8);

        // R10 disabled pin source
        pin_fault = 2'b11;
        measure(20, 0, h, l, b, s, t);
        check(h == 8 && l == 12, "R10 outputs unaffected", h, 8);
        check(stop_flag == 1'b0, "R10 flag stays clear", int'(stop_flag), 0);
        pin_fault = 2'b00;

        // R8 pin source enabled
        wr(4, 4);
        @(negedge clk);
        pin_fault = 2'b01;
        @(negedge clk);
        pin_fault = 2'b00;
        check(stop_flag == 1'b1, "R8 pin source", int'(stop_flag), 1);
        measure(10, 1, h, l, b, s, t);
        check(h + l == 0, "R8 pin kill", h + l, 0);
        wr(5, 1);
        check(stop_flag == 1'b0, "R9 clear after pin", int'(stop_flag), 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 100000; i++) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog all act=%0d exp=%0d", cyc, 100000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule